// File: doc/BRIEF.md
# Data Memory Effective Address Generator

This block turns the file operand of a byte-oriented or bit-oriented instruction into a 12-bit data memory address for an 8-bit microcontroller core. It picks one of three resolution paths. Direct addressing joins the bank select value to the operand. Access-bank mapping folds the operand into either the bottom bank or the top bank. In extended mode, a low access-bank operand can instead be taken as an unsigned offset added to a pointer register. In extended mode that pointer acts as a stack or frame base, so small operands address locations relative to it and not fixed locations.

The core raises `req_i` for one cycle with the instruction's operand fields. It also sets `file_op_i` to say whether the instruction addresses data memory at all. One clock later the block presents the address, a 2-bit code for the path it took, and a valid strobe. Instructions with only inherent or literal operands never raise the strobe. Every path stays inside the same linear 12-bit space.

Top module: `dm_addr_gen`

## Requirements
- R1: A synchronous active-high reset drives `addr_o`, `mode_o` and `valid_o` to zero at the next clock edge, whatever the request inputs are.
- R2: `valid_o` is 1 exactly in the cycle after a clock edge at which `req_i` and `file_op_i` were both 1. Otherwise it is 0.
- R3: When `access_sel_i` is 1, the address is `{bsr_i, operand_i}` and `mode_o` is 2'b00. This holds whether extended mode is on or off.
- R4: When `ext_en_i` is 1, `access_sel_i` is 0 and `operand_i` is at most 0x5F, the address is `fsr2_i` plus the operand taken as an unsigned number, and `mode_o` is 2'b10.
- R5: The pointer-plus-offset sum of R4 wraps modulo 4096, and the carry out of bit 11 is dropped (for example 0xFF0 + 0x5F gives 0x04F).
- R6: When `ext_en_i` is 1, `access_sel_i` is 0 and `operand_i` is 0x60 or above, the pointer is not used. The address is `{4'hF, operand_i}` and `mode_o` is 2'b01.
- R7: When `ext_en_i` is 0 and `access_sel_i` is 0, operands 0x00 to 0x7F map to `{4'h0, operand_i}` and operands 0x80 to 0xFF map to `{4'hF, operand_i}`, with `mode_o` 2'b01. This includes operands 0x00 to 0x5F.
- R8: A request with `file_op_i` 0, or a cycle without `req_i`, leaves `addr_o` and `mode_o` at their previous values and gives `valid_o` 0.
- R9: `mode_o` never takes the value 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | One-cycle request strobe |
| file_op_i | input | 1 | 1 when the instruction addresses data memory through its file operand |
| operand_i | input | 8 | File operand field of the instruction |
| access_sel_i | input | 1 | 0 selects access-bank addressing, 1 selects the bank register |
| bsr_i | input | 4 | Bank select register |
| fsr2_i | input | 12 | Pointer used as base in indexed mode |
| ext_en_i | input | 1 | Extended mode enable |
| addr_o | output | 12 | Registered effective address |
| mode_o | output | 2 | Path taken: 00 direct, 01 access bank, 10 indexed |
| valid_o | output | 1 | Registered strobe, one cycle after a file-addressing request |

## Verification
Every result is due exactly one clock edge after the edge that captured the request, because the address, the path code and the strobe all come from one register stage. The driver changes inputs on the falling edge and pushes the expected item into a queue. The monitor pops that item one nanosecond after the next rising edge and compares it, so each comparison lines up with that single-cycle latency. Requests that are held or have no file operand push an item that repeats the last address and mode. This shows at the ports that nothing changed.

// File: rtl/dmag_pkg.sv
package dmag_pkg;

  typedef enum logic [1:0] {
    PATH_DIRECT  = 2'b00,
    PATH_ACCESS  = 2'b01,
    PATH_INDEXED = 2'b10
  } path_e;

endpackage

// File: rtl/dmag_classify.sv
module dmag_classify
  import dmag_pkg::*;
#(
  parameter int OPER_W      = 8,
  parameter int IDX_MAX     = 'h5F,
  parameter int LOW_MAX_STD = 'h7F
) (
  input  logic [OPER_W-1:0] operand_i,
  input  logic              access_sel_i,
  input  logic              ext_en_i,
  output path_e             path_o,
  output logic              low_bank_o
);

  localparam logic [OPER_W-1:0] IDX_LIM = OPER_W'(IDX_MAX);
  localparam logic [OPER_W-1:0] STD_LIM = OPER_W'(LOW_MAX_STD);

  logic in_idx_window;
  logic [OPER_W-1:0] low_limit;

  assign in_idx_window = (operand_i <= IDX_LIM);
  // with extended mode on, the bottom-bank window shrinks to the indexed window
  assign low_limit     = ext_en_i ? IDX_LIM : STD_LIM;
  assign low_bank_o    = (operand_i <= low_limit);

  always_comb begin
    if (access_sel_i)                       path_o = PATH_DIRECT;
    else if (ext_en_i && in_idx_window)     path_o = PATH_INDEXED;
    else                                    path_o = PATH_ACCESS;
  end

endmodule

// File: rtl/dmag_resolve.sv
module dmag_resolve
  import dmag_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int OPER_W = 8,
  parameter int BANK_W = 4
) (
  input  path_e             path_i,
  input  logic              low_bank_i,
  input  logic [OPER_W-1:0] operand_i,
  input  logic [BANK_W-1:0] bsr_i,
  input  logic [ADDR_W-1:0] fsr2_i,
  output logic [ADDR_W-1:0] addr_o
);

  localparam int PAD_W = ADDR_W - OPER_W;
  localparam logic [BANK_W-1:0] TOP_BANK = '1;
  localparam logic [BANK_W-1:0] BOT_BANK = '0;

  function automatic logic [ADDR_W-1:0] bank_join(input logic [BANK_W-1:0] bank,
                                                  input logic [OPER_W-1:0] off);
    return {bank, off};
  endfunction

  function automatic logic [ADDR_W-1:0] wrap_add(input logic [ADDR_W-1:0] base,
                                                 input logic [OPER_W-1:0] off);
    logic [ADDR_W-1:0] ext_off;
    ext_off = {{PAD_W{1'b0}}, off};
    return base + ext_off;
  endfunction

  logic [ADDR_W-1:0] direct_addr, access_addr, indexed_addr;

  assign direct_addr  = bank_join(bsr_i, operand_i);
  assign access_addr  = bank_join(low_bank_i ? BOT_BANK : TOP_BANK, operand_i);
  assign indexed_addr = wrap_add(fsr2_i, operand_i);

  always_comb begin
    unique case (path_i)
      PATH_DIRECT:  addr_o = direct_addr;
      PATH_INDEXED: addr_o = indexed_addr;
      default:      addr_o = access_addr;
    endcase
  end

endmodule

// File: rtl/dmag_stage.sv
module dmag_stage
  import dmag_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  path_e             path_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [1:0]        mode_o,
  output logic              valid_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_o  <= '0;
      mode_o  <= 2'b00;
      valid_o <= 1'b0;
    end else begin
      valid_o <= take_i;
      if (take_i) begin
        addr_o <= addr_i;
        mode_o <= path_i;
      end
    end
  end

endmodule

// File: rtl/dm_addr_gen.sv
module dm_addr_gen
  import dmag_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int OPER_W      = 8,
  parameter int BANK_W      = ADDR_W - OPER_W,
  parameter int IDX_MAX     = 'h5F,
  parameter int LOW_MAX_STD = 'h7F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic              file_op_i,
  input  logic [OPER_W-1:0] operand_i,
  input  logic              access_sel_i,
  input  logic [BANK_W-1:0] bsr_i,
  input  logic [ADDR_W-1:0] fsr2_i,
  input  logic              ext_en_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [1:0]        mode_o,
  output logic              valid_o
);

  path_e             path_sel;
  logic              low_bank;
  logic              take;
  logic [ADDR_W-1:0] next_addr;

  assign take = req_i & file_op_i;

  dmag_classify #(
    .OPER_W(OPER_W), .IDX_MAX(IDX_MAX), .LOW_MAX_STD(LOW_MAX_STD)
  ) u_classify (
    .operand_i(operand_i), .access_sel_i(access_sel_i), .ext_en_i(ext_en_i),
    .path_o(path_sel), .low_bank_o(low_bank)
  );

  dmag_resolve #(
    .ADDR_W(ADDR_W), .OPER_W(OPER_W), .BANK_W(BANK_W)
  ) u_resolve (
    .path_i(path_sel), .low_bank_i(low_bank), .operand_i(operand_i),
    .bsr_i(bsr_i), .fsr2_i(fsr2_i), .addr_o(next_addr)
  );

  dmag_stage #(
    .ADDR_W(ADDR_W)
  ) u_stage (
    .clk(clk), .rst(rst), .take_i(take), .addr_i(next_addr), .path_i(path_sel),
    .addr_o(addr_o), .mode_o(mode_o), .valid_o(valid_o)
  );

endmodule

// File: rtl/dmag_chk.sv
module dmag_chk #(
  parameter int ADDR_W  = 12,
  parameter int OPER_W  = 8,
  parameter int BANK_W  = 4,
  parameter int IDX_MAX = 'h5F
) (
  input logic              clk,
  input logic              rst,
  input logic              req_i,
  input logic              file_op_i,
  input logic [OPER_W-1:0] operand_i,
  input logic              access_sel_i,
  input logic [BANK_W-1:0] bsr_i,
  input logic [ADDR_W-1:0] fsr2_i,
  input logic              ext_en_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic [1:0]        mode_o,
  input logic              valid_o,
  input logic [1:0]        path_sel
);

  localparam logic [OPER_W-1:0] IDX_LIM = OPER_W'(IDX_MAX);

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (addr_o == '0 && mode_o == 2'b00 && !valid_o));

  // R2
  valid_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    (req_i && file_op_i) |=> valid_o);

  // R2
  valid_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(req_i && file_op_i) |=> !valid_o);

  // R3
  direct_path_chk: assert property (@(posedge clk) disable iff (rst)
    (req_i && file_op_i && access_sel_i) |=>
      (mode_o == 2'b00 && addr_o == {$past(bsr_i), $past(operand_i)}));

  // R4
  indexed_path_chk: assert property (@(posedge clk) disable iff (rst)
    (req_i && file_op_i && ext_en_i && !access_sel_i && operand_i <= IDX_LIM) |=>
      (mode_o == 2'b10 &&
       addr_o == ADDR_W'($past(fsr2_i) + {{(ADDR_W-OPER_W){1'b0}}, $past(operand_i)})));

  // R8
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !(req_i && file_op_i) |=> ($stable(addr_o) && $stable(mode_o)));

  // R9
  mode_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (req_i && file_op_i) |=> (mode_o != 2'b11 && mode_o == $past(path_sel)));

endmodule

bind dm_addr_gen dmag_chk #(
  .ADDR_W(ADDR_W), .OPER_W(OPER_W), .BANK_W(BANK_W), .IDX_MAX(IDX_MAX)
) u_chk (
  .clk(clk), .rst(rst), .req_i(req_i), .file_op_i(file_op_i),
  .operand_i(operand_i), .access_sel_i(access_sel_i), .bsr_i(bsr_i),
  .fsr2_i(fsr2_i), .ext_en_i(ext_en_i), .addr_o(addr_o), .mode_o(mode_o),
  .valid_o(valid_o), .path_sel(path_sel)
);

// File: tb/dm_addr_gen_tb_top.sv
`timescale 1ns/1ps
module dm_addr_gen_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_i = 1'b0;
  logic        file_op_i = 1'b0;
  logic [7:0]  operand_i = '0;
  logic        access_sel_i = 1'b0;
  logic [3:0]  bsr_i = '0;
  logic [11:0] fsr2_i = '0;
  logic        ext_en_i = 1'b0;
  logic [11:0] addr_o;
  logic [1:0]  mode_o;
  logic        valid_o;

  always #2.5 clk = ~clk;

  dm_addr_gen dut_i (
    .clk(clk), .rst(rst), .req_i(req_i), .file_op_i(file_op_i),
    .operand_i(operand_i), .access_sel_i(access_sel_i), .bsr_i(bsr_i),
    .fsr2_i(fsr2_i), .ext_en_i(ext_en_i), .addr_o(addr_o), .mode_o(mode_o),
    .valid_o(valid_o)
  );

  typedef struct {
    logic        v;
    logic [11:0] a;
    logic [1:0]  m;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  int          n_vec  = 0;
  int          n_fail = 0;
  logic [11:0] mdl_addr = '0;
  logic [1:0]  mdl_mode = '0;
  bit          finished = 0;

  // Independent model of the addressing rules
  task automatic model(input logic [7:0] op, input logic a, input logic [3:0] bsr,
                       input logic [11:0] base, input logic ext,
                       output logic [11:0] ea, output logic [1:0] md);
    int sum;
    if (a) begin
      ea = {bsr, op}; md = 2'b00;                       // R3
    end else if (ext && op < 8'h60) begin
      sum = int'(base) + int'(op);
      ea = 12'(sum % 4096); md = 2'b10;                 // R4 R5
    end else if (!ext && op < 8'h80) begin
      ea = {4'h0, op}; md = 2'b01;                      // R7
    end else begin
      ea = {4'hF, op}; md = 2'b01;                      // R6 R7
    end
  endtask

  task automatic drive(input logic rq, input logic fo, input logic [7:0] op,
                       input logic a, input logic [3:0] bsr, input logic [11:0] base,
                       input logic ext, input string tag);
    exp_t e;
    logic [11:0] ea;
    logic [1:0]  md;
    @(negedge clk);
    req_i = rq; file_op_i = fo; operand_i = op; access_sel_i = a;
    bsr_i = bsr; fsr2_i = base; ext_en_i = ext;
    if (rq && fo) begin
      model(op, a, bsr, base, ext, ea, md);
      mdl_addr = ea; mdl_mode = md;
    end
    e.v = rq && fo; e.a = mdl_addr; e.m = mdl_mode; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst = 1'b1; req_i = 1'b1; file_op_i = 1'b1; access_sel_i = 1'b1;
    bsr_i = 4'hA; operand_i = 8'h33;
    @(negedge clk);
    n_vec++;
    if (addr_o !== 12'h000 || mode_o !== 2'b00 || valid_o !== 1'b0) begin
      n_fail++;
      $display("FAIL %s R1: got addr=%h mode=%b valid=%b exp addr=000 mode=00 valid=0",
               tag, addr_o, mode_o, valid_o);
    end
    rst = 1'b0; req_i = 1'b0;
    mdl_addr = '0; mdl_mode = '0;
  endtask

  // Monitor: one result per driven cycle, due one edge later
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        n_vec++;
        if (valid_o !== e.v || addr_o !== e.a || mode_o !== e.m) begin
          n_fail++;
          $display("FAIL %s: got v=%b addr=%h mode=%b exp v=%b addr=%h mode=%b",
                   e.tag, valid_o, addr_o, mode_o, e.v, e.a, e.m);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset("R1 initial reset");
    drive(1, 1, 8'h42, 1, 4'h3, 12'h800, 0, "R3 direct ext off");
    drive(1, 1, 8'h10, 1, 4'h7, 12'h800, 1, "R3 direct ext on low operand");
    drive(1, 1, 8'h00, 0, 4'h7, 12'h123, 1, "R4 indexed zero offset");
    drive(1, 1, 8'h5F, 0, 4'h7, 12'h200, 1, "R4 indexed top of window");
    drive(1, 1, 8'h5F, 0, 4'h0, 12'hFF0, 1, "R5 wrap 0xFF0+0x5F");
    drive(1, 1, 8'h01, 0, 4'h0, 12'hFFF, 1, "R5 wrap 0xFFF+1");
    drive(1, 1, 8'h60, 0, 4'h2, 12'h300, 1, "R6 ext first non-indexed");
    drive(1, 1, 8'h7F, 0, 4'h2, 12'h300, 1, "R6 ext 0x7F top bank");
    drive(1, 1, 8'hC4, 0, 4'h2, 12'h300, 1, "R6 ext high operand");
    drive(1, 1, 8'h5F, 0, 4'h2, 12'h300, 0, "R7 ext off 0x5F bank0");
    drive(1, 1, 8'h7F, 0, 4'h2, 12'h300, 0, "R7 ext off 0x7F bank0");
    drive(1, 1, 8'h80, 0, 4'h2, 12'h300, 0, "R7 ext off 0x80 top bank");
    drive(1, 0, 8'h12, 1, 4'h9, 12'h555, 1, "R8 R2 literal instruction");
    drive(0, 1, 8'h05, 0, 4'h9, 12'h555, 1, "R8 R2 no request");
    drive(1, 1, 8'hFF, 1, 4'hF, 12'h000, 1, "R3 direct 0xFFF");
    for (int i = 0; i < 300; i++) begin
      drive(1'($urandom_range(0, 7) != 0), 1'($urandom_range(0, 5) != 0),
            8'($urandom), 1'($urandom), 4'($urandom), 12'($urandom), 1'($urandom),
            "R2 R3 R4 R6 R7 R9 random");
    end
    drive(0, 0, 8'h00, 0, 4'h0, 12'h000, 0, "R8 idle");
    do_reset("R1 reset after traffic");
    drive(1, 1, 8'h20, 0, 4'h0, 12'h010, 1, "R4 after reset");
    drive(0, 0, 8'h00, 0, 4'h0, 12'h000, 0, "R2 drain");
    repeat (3) @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule